// File: doc/BRIEF.md
# Branch and Jump Resolution Unit

This execute-stage unit decides, for one instruction per clock, whether control flow is redirected and where to. A conditional branch compares two register operands under one of six conditions. When the condition holds, the new fetch address is the instruction address plus a sign-extended displacement. When it does not hold, the address is the next sequential one. Jumps take the same comparison path: the unit forces both compared values to one operand and selects the equality condition, so a jump is always taken.

Both jump forms write a return address (instruction address plus 4) to a destination register. The register-indirect form takes its target from the first operand plus the displacement, with bit 0 cleared. The comparator, the target adder and the return-address adder all work in parallel in one cycle. The results are registered once and marked with a valid bit, so the pipeline sees a fixed latency of one clock and a new instruction can enter every cycle.

Top module: `brj_unit`

## Requirements
- R1: While reset is asserted, and on every cycle where `out_valid` is low, `out_taken` and `out_wr_en` are low. Reset is asynchronous and active low.
- R2: `out_valid` equals `in_valid` from the previous clock. All result outputs belong to the instruction presented on that previous clock.
- R3: For a branch (`in_kind` = 01), the condition field selects the test. 000 is equal, 001 is not equal, 100 is signed less-than, 101 is signed greater-or-equal, 110 is unsigned less-than and 111 is unsigned greater-or-equal. The codes 010 and 011 are never taken.
- R4: A taken branch targets `in_pc + in_disp`. A not-taken branch targets `in_pc + 4`.
- R5: A branch never asserts `out_wr_en`.
- R6: A direct jump (`in_kind` = 10) is taken whatever the operands and the condition field are, and it targets `in_pc + in_disp`.
- R7: A register-indirect jump (`in_kind` = 11) is taken. It targets `in_opa + in_disp` with bit 0 forced to 0.
- R8: For any valid instruction, `out_link` is `in_pc + 4`. A jump asserts `out_wr_en` with `out_wr_idx = in_rd` only when `in_rd` is not 0. With `in_rd` = 0 there is no write.
- R9: A valid entry of kind 00 (not a control-transfer instruction) is not taken, writes no register, and targets `in_pc + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction present this cycle |
| in_kind | input | 2 | 00 none, 01 branch, 10 direct jump, 11 register-indirect jump |
| in_cond | input | 3 | Branch condition code |
| in_opa | input | 32 | Left comparison operand and indirect jump base |
| in_opb | input | 32 | Right comparison operand |
| in_pc | input | 32 | Address of the instruction |
| in_disp | input | 32 | Sign-extended displacement |
| in_rd | input | 5 | Destination register index |
| out_valid | output | 1 | Result valid |
| out_taken | output | 1 | Control flow redirected |
| out_target | output | 32 | Next fetch address |
| out_link | output | 32 | Return address |
| out_wr_en | output | 1 | Register write request |
| out_wr_idx | output | 5 | Register index to write |

## Verification
The assertions that look one cycle back assume that the inputs are held at known values, with `in_valid` low, while reset is asserted. This gives the first sampled history a defined value. The bench drives every input to zero during reset and changes inputs only on falling edges, so each rising edge sees settled values. The stimulus uses the two unused condition codes, and the random phase draws the condition code and the kind across their full ranges. This lets the assertions see every code, including the ones that are never taken.

// File: rtl/brj_pkg.sv
package brj_pkg;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_BR   = 2'b01,
        KIND_JAL  = 2'b10,
        KIND_JALR = 2'b11
    } kind_e;

    typedef enum logic [2:0] {
        COND_EQ  = 3'b000,
        COND_NE  = 3'b001,
        COND_RS2 = 3'b010,
        COND_RS3 = 3'b011,
        COND_LT  = 3'b100,
        COND_GE  = 3'b101,
        COND_LTU = 3'b110,
        COND_GEU = 3'b111
    } cond_e;

endpackage

// File: rtl/brj_cond.sv
module brj_cond #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] lhs,
    input  logic [XLEN-1:0] rhs,
    input  logic [2:0]      cond,
    output logic            hit
);
    import brj_pkg::*;

    logic eq_w;
    logic slt_w;
    logic ult_w;

    always_comb begin
        eq_w  = (lhs == rhs);
        slt_w = ($signed(lhs) < $signed(rhs));
        ult_w = (lhs < rhs);
        case (cond_e'(cond))
            COND_EQ:  hit = eq_w;
            COND_NE:  hit = !eq_w;
            COND_LT:  hit = slt_w;
            COND_GE:  hit = !slt_w;
            COND_LTU: hit = ult_w;
            COND_GEU: hit = !ult_w;
            default:  hit = 1'b0;
        endcase
    end

    // R3: equal operands can never satisfy a strict less-than test
    always_comb begin
        if (eq_w) begin
            a_r3_eq_not_less: assert (!slt_w && !ult_w);
        end
    end
endmodule

// File: rtl/brj_addr.sv
module brj_addr #(
    parameter int XLEN     = 32,
    parameter int LINK_INC = 4
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] base_reg,
    input  logic [XLEN-1:0] disp,
    input  logic            use_reg,
    input  logic            taken,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] link
);
    logic [XLEN-1:0] pc_rel_w;
    logic [XLEN-1:0] reg_rel_w;
    logic [XLEN-1:0] seq_w;

    // All three adders evaluate in parallel; the selection is last.
    always_comb begin
        pc_rel_w  = pc + disp;
        reg_rel_w = base_reg + disp;
        reg_rel_w[0] = 1'b0;
        seq_w     = pc + XLEN'(LINK_INC);
        link      = seq_w;
        if (!taken) begin
            target = seq_w;
        end else if (use_reg) begin
            target = reg_rel_w;
        end else begin
            target = pc_rel_w;
        end
    end

    // R7: a register-relative target is always halfword aligned
    always_comb begin
        if (taken && use_reg) begin
            a_r7_reg_target_even: assert (target[0] == 1'b0);
        end
    end
endmodule

// File: rtl/brj_unit.sv
module brj_unit #(
    parameter int XLEN     = 32,
    parameter int REG_AW   = 5,
    parameter int LINK_INC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [2:0]        in_cond,
    input  logic [XLEN-1:0]   in_opa,
    input  logic [XLEN-1:0]   in_opb,
    input  logic [XLEN-1:0]   in_pc,
    input  logic [XLEN-1:0]   in_disp,
    input  logic [REG_AW-1:0] in_rd,
    output logic              out_valid,
    output logic              out_taken,
    output logic [XLEN-1:0]   out_target,
    output logic [XLEN-1:0]   out_link,
    output logic              out_wr_en,
    output logic [REG_AW-1:0] out_wr_idx
);
    import brj_pkg::*;

    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic [XLEN-1:0]   target;
        logic [XLEN-1:0]   link;
        logic              wr_en;
        logic [REG_AW-1:0] wr_idx;
    } res_t;

    res_t res_d, res_q;

    kind_e           kind_w;
    logic            is_jump_w;
    logic            is_br_w;
    logic [XLEN-1:0] cmp_rhs_w;
    logic [2:0]      cmp_cond_w;
    logic            cmp_hit_w;
    logic            taken_w;
    logic [XLEN-1:0] target_w;
    logic [XLEN-1:0] link_w;

    // Jumps reuse the comparator: same value on both sides, equality test.
    always_comb begin
        kind_w     = kind_e'(in_kind);
        is_jump_w  = (kind_w == KIND_JAL) || (kind_w == KIND_JALR);
        is_br_w    = (kind_w == KIND_BR);
        cmp_rhs_w  = is_jump_w ? in_opa : in_opb;
        cmp_cond_w = is_jump_w ? 3'(COND_EQ) : in_cond;
    end

    brj_cond #(.XLEN(XLEN)) u_cond (
        .lhs  (in_opa),
        .rhs  (cmp_rhs_w),
        .cond (cmp_cond_w),
        .hit  (cmp_hit_w)
    );

    always_comb begin
        taken_w = (is_br_w || is_jump_w) && cmp_hit_w;
    end

    brj_addr #(.XLEN(XLEN), .LINK_INC(LINK_INC)) u_addr (
        .pc       (in_pc),
        .base_reg (in_opa),
        .disp     (in_disp),
        .use_reg  (kind_w == KIND_JALR),
        .taken    (taken_w),
        .target   (target_w),
        .link     (link_w)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid  = 1'b1;
            res_d.taken  = taken_w;
            res_d.target = target_w;
            res_d.link   = link_w;
            res_d.wr_en  = is_jump_w && (in_rd != ZERO_REG);
            res_d.wr_idx = in_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    always_comb begin
        out_valid  = res_q.valid;
        out_taken  = res_q.taken;
        out_target = res_q.target;
        out_link   = res_q.link;
        out_wr_en  = res_q.wr_en;
        out_wr_idx = res_q.wr_idx;
    end

    // R1: nothing is taken or written without a valid result
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_taken && !out_wr_en));

    // R2: one cycle of latency on the valid bit
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_bubble_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: a branch never writes a register
    a_r5_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b01) |=> !out_wr_en);

    // R6: every jump is taken
    a_r6_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind[1]) |=> out_taken);

    // R8: register 0 is never written
    a_r8_no_x0_write: assert property (@(posedge clk) disable iff (!rst_n)
        out_wr_en |-> (out_wr_idx != ZERO_REG));

    // R4: a not-taken result falls through to the next instruction
    a_r4_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_kind[1]) |=> (out_taken || out_target == $past(in_pc) + XLEN'(LINK_INC)));

    // R9: a non-control entry does nothing
    a_r9_none_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'b00) |=> (!out_taken && !out_wr_en));
endmodule

// File: tb/brj_unit_bench.sv
module brj_unit_bench;

    typedef struct {
        logic        taken;
        logic [31:0] target;
        logic [31:0] link;
        logic        wr_en;
        logic [4:0]  wr_idx;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_kind = '0;
    logic [2:0]  in_cond = '0;
    logic [31:0] in_opa = '0;
    logic [31:0] in_opb = '0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_disp = '0;
    logic [4:0]  in_rd = '0;
    logic        out_valid;
    logic        out_taken;
    logic [31:0] out_target;
    logic [31:0] out_link;
    logic        out_wr_en;
    logic [4:0]  out_wr_idx;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    brj_unit u_brj_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
        .in_cond(in_cond), .in_opa(in_opa), .in_opb(in_opb), .in_pc(in_pc),
        .in_disp(in_disp), .in_rd(in_rd), .out_valid(out_valid),
        .out_taken(out_taken), .out_target(out_target), .out_link(out_link),
        .out_wr_en(out_wr_en), .out_wr_idx(out_wr_idx)
    );

    task automatic chk(input string what, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [1:0] k, input logic [2:0] c,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] pc, input logic [31:0] d,
                                   input logic [4:0] rd);
        exp_t e;
        logic hit;
        case (c)
            3'b000: hit = (a == b);
            3'b001: hit = (a != b);
            3'b100: hit = ($signed(a) < $signed(b));
            3'b101: hit = ($signed(a) >= $signed(b));
            3'b110: hit = (a < b);
            3'b111: hit = (a >= b);
            default: hit = 1'b0;
        endcase
        e.link   = pc + 32'd4;
        e.wr_idx = rd;
        e.wr_en  = 1'b0;
        case (k)
            2'b01: begin
                e.taken  = hit;
                e.target = hit ? pc + d : pc + 32'd4;
                e.tag    = "R3/R4/R5";
            end
            2'b10: begin
                e.taken  = 1'b1;
                e.target = pc + d;
                e.wr_en  = (rd != 5'd0);
                e.tag    = "R6/R8";
            end
            2'b11: begin
                e.taken  = 1'b1;
                e.target = (a + d) & ~32'd1;
                e.wr_en  = (rd != 5'd0);
                e.tag    = "R7/R8";
            end
            default: begin
                e.taken  = 1'b0;
                e.target = pc + 32'd4;
                e.tag    = "R9";
            end
        endcase
        return e;
    endfunction

    task automatic issue(input logic [1:0] k, input logic [2:0] c,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] pc, input logic [31:0] d,
                         input logic [4:0] rd);
        @(negedge clk);
        in_valid = 1'b1; in_kind = k; in_cond = c; in_opa = a; in_opb = b;
        in_pc = pc; in_disp = d; in_rd = rd;
        sb.push_back(model(k, c, a, b, pc, d, rd));
    endtask

    task automatic bubble();
        @(negedge clk);
        in_valid = 1'b0;
        in_kind = $urandom; in_rd = $urandom; in_pc = $urandom;
    endtask

    // Monitor: compares results with the scoreboard; idle cycles checked for R1.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    chk("unexpected valid (R2)", "R2", 32'(out_valid), 32'd0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("taken", e.tag, 32'(out_taken), 32'(e.taken));
                    chk("target", e.tag, out_target, e.target);
                    chk("link R8", "R8", out_link, e.link);
                    chk("wr_en", e.tag, 32'(out_wr_en), 32'(e.wr_en));
                    if (e.wr_en) chk("wr_idx R8", "R8", 32'(out_wr_idx), 32'(e.wr_idx));
                end
            end else begin
                chk("idle taken R1", "R1", 32'(out_taken), 32'd0);
                chk("idle wr_en R1", "R1", 32'(out_wr_en), 32'd0);
            end
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("reset valid R1", "R1", 32'(out_valid), 32'd0);
        chk("reset taken R1", "R1", 32'(out_taken), 32'd0);
        chk("reset wr_en R1", "R1", 32'(out_wr_en), 32'd0);
        rst_n = 1'b1;

        // R3 R4: each condition, signed versus unsigned corner (-1 vs 1)
        issue(2'b01, 3'b000, 32'd7, 32'd7, 32'h100, 32'h40, 5'd3);
        issue(2'b01, 3'b000, 32'd7, 32'd8, 32'h104, 32'h40, 5'd3);
        issue(2'b01, 3'b001, 32'd7, 32'd8, 32'h108, 32'hFFFF_FFF0, 5'd0);
        issue(2'b01, 3'b001, 32'd9, 32'd9, 32'h10C, 32'h20, 5'd1);
        issue(2'b01, 3'b100, 32'hFFFF_FFFF, 32'd1, 32'h110, 32'h80, 5'd2);
        issue(2'b01, 3'b110, 32'hFFFF_FFFF, 32'd1, 32'h114, 32'h80, 5'd2);
        issue(2'b01, 3'b101, 32'hFFFF_FFFF, 32'd1, 32'h118, 32'h80, 5'd2);
        issue(2'b01, 3'b111, 32'hFFFF_FFFF, 32'd1, 32'h11C, 32'h80, 5'd2);
        issue(2'b01, 3'b101, 32'h8000_0000, 32'h8000_0000, 32'h120, 32'h8, 5'd2);
        issue(2'b01, 3'b110, 32'd5, 32'd5, 32'h124, 32'h8, 5'd2);
        // R3: unused codes never taken, even with equal operands
        issue(2'b01, 3'b010, 32'd5, 32'd5, 32'h128, 32'h8, 5'd2);
        issue(2'b01, 3'b011, 32'd1, 32'd2, 32'h12C, 32'h8, 5'd2);
        bubble();
        // R6: jump with unequal operands and a not-equal code is still taken
        issue(2'b10, 3'b001, 32'd1, 32'd2, 32'h200, 32'hFFFF_FF00, 5'd1);
        // R8: jump to x0 writes nothing
        issue(2'b10, 3'b000, 32'd0, 32'd0, 32'h204, 32'h10, 5'd0);
        // R7: odd indirect sum is cleared to even
        issue(2'b11, 3'b111, 32'h1001, 32'd5, 32'h300, 32'h4, 5'd31);
        issue(2'b11, 3'b100, 32'h2000, 32'd0, 32'h304, 32'hFFFF_FFFF, 5'd0);
        // R9: non-control entry
        issue(2'b00, 3'b000, 32'd3, 32'd3, 32'h400, 32'h100, 5'd4);
        bubble();
        bubble();
        // Random mix including back-to-back and gaps
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 5) == 0) begin
                bubble();
            end else begin
                logic [31:0] a;
                a = $urandom;
                issue(2'($urandom), 3'($urandom), a,
                      (($urandom % 3) == 0) ? a : 32'($urandom),
                      {$urandom} & ~32'd3, 32'($urandom), 5'($urandom));
            end
        end
        bubble();
        bubble();
        @(negedge clk);
        // R2: every issued instruction produced exactly one result
        chk("pending results R2", "R2", 32'(sb.size()), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule